// File: doc/BRIEF.md
# Register-Cached Operand Stack

This block is the operand stack of a zero-address machine. Commands carry no operand address. Every command works on the top of the stack only.
- A push places a word on top.
- A pop discards the top.
- Four binary operations (add, subtract, AND, OR) take the two top words and leave one result as the new top.

The stack pointer moves with each command without further help.

The four newest entries sit in a register window, which feeds the ALU directly. Older entries live in an external memory region reached through a request/acknowledge port.
- A push into a full window first writes the oldest register entry out to memory.
- A pop or operation that leaves a single register entry, while memory still holds entries, reads one word back.

While either transfer is under way the block reports busy and holds off further commands; it does not drop them. Underflow and overflow attempts leave the stack untouched and raise sticky flags.

Top module: `opstk_unit`

## Requirements
- R1: A push command (code 0) with `cmd_data` makes `top_data` equal that word and raises `depth` by one; the previous top becomes the second entry.
- R2: Add (code 2), AND (code 4) and OR (code 5) replace the two top entries by their sum (modulo 2^DATA_W), bitwise AND, or bitwise OR, and lower `depth` by one.
- R3: Subtract (code 3) leaves second-entry minus top-entry as the new top (postfix order) and lowers `depth` by one.
- R4: A pop (code 1) lowers `depth` by one and the former second entry becomes `top_data`.
- R5: A push while all WIN register entries are valid first writes the oldest register entry to memory, at address equal to the number of entries already in memory (`mem_we`=1, addresses grow upward from 0). While this spill is pending `cmd_ready` stays low and the push is then taken.
- R6: A pop or operation that leaves one register entry while memory is not empty reads the highest occupied memory address back into the window. `busy` is high and `cmd_ready` is low until the read is acknowledged.
- R7: Once raised, `mem_req` stays high with stable `mem_addr` and `mem_we` until the cycle in which `mem_ack` is sampled high.
- R8: A pop or operation when `depth` is below 2 sets the sticky `underflow` flag and leaves depth and contents unchanged.
- R9: A push when `depth` equals WIN+MEM_DEPTH sets the sticky `overflow` flag, causes no memory traffic and leaves the stack unchanged.
- R10: Command codes 6 and 7 are consumed with no effect on `depth`, `top_data` or the flags.
- R11: After reset `depth` is 0, `busy`, `mem_req`, `underflow` and `overflow` are 0, and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code: 0 push, 1 pop, 2 add, 3 sub, 4 and, 5 or |
| cmd_data | input | DATA_W | Word for a push |
| cmd_ready | output | 1 | Command taken at this edge when valid |
| busy | output | 1 | Spill or refill in progress |
| top_data | output | DATA_W | Current top entry |
| depth | output | clog2(WIN+MEM_DEPTH+1) | Stack pointer: number of entries |
| underflow | output | 1 | Sticky underflow flag |
| overflow | output | 1 | Sticky overflow flag |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write (spill), 0 = read (refill) |
| mem_addr | output | clog2(MEM_DEPTH) | Memory word address |
| mem_wdata | output | DATA_W | Word being spilled |
| mem_ack | input | 1 | Transfer done; read data valid |
| mem_rdata | input | DATA_W | Word returned by a refill |

## Verification
Two functions can meet in one command:
- A push against a full window makes the spill and the push share one command.
- An operation that shrinks the window to a single entry makes the arithmetic result and the refill share one command.

Both cases are provoked by driving the stack past four entries and back down, in directed runs and in a long random walk. The memory model acknowledges each transfer after a random 0 to 2 cycle delay. Each such command is judged on the memory address, the data and the transfer count observed at the port, the stall seen on `cmd_ready` or `busy`, and the final top and depth against a bench model.

// File: rtl/opstk_pkg.sv
package opstk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    WN_HOLD,
    WN_PUSH,
    WN_POP,
    WN_ALU,
    WN_FILL
  } wop_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPILL,
    ST_REFILL
  } st_e;
endpackage

// File: rtl/opstk_alu.sv
module opstk_alu
  import opstk_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] nos,
  input  logic [W-1:0] tos,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_ADD:  y = nos + tos;
      OP_SUB:  y = nos - tos;
      OP_AND:  y = nos & tos;
      OP_OR:   y = nos | tos;
      default: y = tos;
    endcase
  end
endmodule

// File: rtl/opstk_window.sv
module opstk_window
  import opstk_pkg::*;
#(
  parameter int W = 16,
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wop_e          wop,
  input  logic [IW-1:0] fill_idx,
  input  logic [W-1:0]  push_d,
  input  logic [W-1:0]  fill_d,
  input  logic [W-1:0]  alu_y,
  output logic [W-1:0]  tos,
  output logic [W-1:0]  nos,
  output logic [W-1:0]  bot
);
  logic [W-1:0] ent [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [W-1:0] q, nxt, dn_v, up_v;
    logic         en;

    if (g == 0) begin : g_first
      assign dn_v = push_d;
    end else begin : g_mid
      assign dn_v = ent[g-1];
    end
    if (g == N-1) begin : g_last
      assign up_v = ent[g];
    end else begin : g_inner
      assign up_v = ent[g+1];
    end

    always_comb begin
      en  = 1'b0;
      nxt = q;
      case (wop)
        WN_PUSH: begin en = 1'b1; nxt = dn_v; end
        WN_POP:  begin en = 1'b1; nxt = up_v; end
        WN_ALU:  begin en = 1'b1; nxt = (g == 0) ? alu_y : up_v; end
        WN_FILL: if (fill_idx == IW'(g)) begin en = 1'b1; nxt = fill_d; end
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nxt;
    end

    assign ent[g] = q;
  end

  assign tos = ent[0];
  assign nos = ent[1];
  assign bot = ent[N-1];
endmodule

// File: rtl/opstk_ctrl.sv
module opstk_ctrl
  import opstk_pkg::*;
#(
  parameter int WIN       = 4,
  parameter int MEM_DEPTH = 8,
  localparam int CW = $clog2(WIN + 1),
  localparam int MW = $clog2(MEM_DEPTH + 1),
  localparam int AW = $clog2(MEM_DEPTH),
  localparam int IW = $clog2(WIN),
  localparam int DW = $clog2(WIN + MEM_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  op_e           op,
  input  logic          mem_ack,
  output logic          cmd_ready,
  output logic          busy,
  output wop_e          wop,
  output logic [IW-1:0] fill_idx,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] depth,
  output logic          underflow,
  output logic          overflow
);
  st_e           state, state_n;
  logic [CW-1:0] reg_cnt, reg_n;
  logic [MW-1:0] mem_cnt, mem_n;
  logic          unf_q, unf_n, ovf_q, ovf_n;
  logic          is_push, is_pop, is_alu, win_full, mem_full;
  logic          need_spill, accept, shallow, adv;

  assign is_push    = (op == OP_PUSH);
  assign is_pop     = (op == OP_POP);
  assign is_alu     = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_OR);
  assign win_full   = (reg_cnt == CW'(WIN));
  assign mem_full   = (mem_cnt == MW'(MEM_DEPTH));
  assign need_spill = cmd_valid && is_push && win_full && !mem_full;
  assign cmd_ready  = (state == ST_IDLE) && !need_spill;
  assign accept     = cmd_valid && cmd_ready;
  assign depth      = DW'(reg_cnt) + DW'(mem_cnt);
  assign shallow    = (depth < DW'(2));
  assign adv        = accept || need_spill || mem_ack;

  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state == ST_SPILL) || (state == ST_REFILL);
  assign mem_we    = (state == ST_SPILL);
  assign mem_addr  = (state == ST_REFILL) ? AW'(mem_cnt - MW'(1)) : AW'(mem_cnt);
  assign fill_idx  = IW'(reg_cnt);
  assign underflow = unf_q;
  assign overflow  = ovf_q;

  always_comb begin
    state_n = state;
    reg_n   = reg_cnt;
    mem_n   = mem_cnt;
    unf_n   = unf_q;
    ovf_n   = ovf_q;
    wop     = WN_HOLD;
    case (state)
      ST_IDLE: begin
        if (need_spill) begin
          state_n = ST_SPILL;
        end else if (accept) begin
          if (is_push) begin
            if (win_full) ovf_n = 1'b1;
            else begin
              wop   = WN_PUSH;
              reg_n = reg_cnt + CW'(1);
            end
          end else if (is_pop || is_alu) begin
            if (shallow) unf_n = 1'b1;
            else begin
              wop   = is_pop ? WN_POP : WN_ALU;
              reg_n = reg_cnt - CW'(1);
              if (reg_cnt == CW'(2) && mem_cnt != '0) state_n = ST_REFILL;
            end
          end
        end
      end
      ST_SPILL: if (mem_ack) begin
        reg_n   = reg_cnt - CW'(1);
        mem_n   = mem_cnt + MW'(1);
        state_n = ST_IDLE;
      end
      ST_REFILL: if (mem_ack) begin
        wop     = WN_FILL;
        reg_n   = reg_cnt + CW'(1);
        mem_n   = mem_cnt - MW'(1);
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      reg_cnt <= '0;
      mem_cnt <= '0;
      unf_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (adv) begin
      state   <= state_n;
      reg_cnt <= reg_n;
      mem_cnt <= mem_n;
      unf_q   <= unf_n;
      ovf_q   <= ovf_n;
    end
  end

  // R1
  push_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_push && !win_full) |=> (depth == $past(depth) + DW'(1)));
  // R5
  spill_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (reg_cnt == CW'(WIN)));
  // R6
  refill_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && mem_cnt != '0) |-> (reg_cnt >= CW'(2)));
  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R8
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R9
  mem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cnt <= MW'(MEM_DEPTH));
endmodule

// File: rtl/opstk_unit.sv
module opstk_unit
  import opstk_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int WIN       = 4,
  parameter int MEM_DEPTH = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_ni,
  input  logic                                   cmd_valid,
  input  logic [2:0]                             cmd_op,
  input  logic [DATA_W-1:0]                      cmd_data,
  output logic                                   cmd_ready,
  output logic                                   busy,
  output logic [DATA_W-1:0]                      top_data,
  output logic [$clog2(WIN+MEM_DEPTH+1)-1:0]     depth,
  output logic                                   underflow,
  output logic                                   overflow,
  output logic                                   mem_req,
  output logic                                   mem_we,
  output logic [$clog2(MEM_DEPTH)-1:0]           mem_addr,
  output logic [DATA_W-1:0]                      mem_wdata,
  input  logic                                   mem_ack,
  input  logic [DATA_W-1:0]                      mem_rdata
);
  localparam int IW = $clog2(WIN);

  logic [1:0]        rst_sync;
  logic              rst_n;
  op_e               op;
  wop_e              wop;
  logic [IW-1:0]     fill_idx;
  logic [DATA_W-1:0] tos, nos, bot, alu_y;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  assign op        = op_e'(cmd_op);
  assign top_data  = tos;
  assign mem_wdata = bot;

  opstk_ctrl #(.WIN(WIN), .MEM_DEPTH(MEM_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .op(op), .mem_ack(mem_ack),
    .cmd_ready(cmd_ready), .busy(busy), .wop(wop), .fill_idx(fill_idx),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .depth(depth),
    .underflow(underflow), .overflow(overflow)
  );

  opstk_window #(.W(DATA_W), .N(WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .wop(wop), .fill_idx(fill_idx), .push_d(cmd_data),
    .fill_d(mem_rdata), .alu_y(alu_y), .tos(tos), .nos(nos), .bot(bot)
  );

  opstk_alu #(.W(DATA_W)) u_alu (
    .op(op), .nos(nos), .tos(tos), .y(alu_y)
  );
endmodule

// File: tb/tb_opstk_unit.sv
module tb_opstk_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int WIN  = 4;
  localparam int MDEP = 8;
  localparam int CAP  = WIN + MDEP;
  localparam int SW   = $clog2(CAP + 1);
  localparam int AW   = $clog2(MDEP);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [DW-1:0] cmd_data = '0;
  logic          cmd_ready, busy, underflow, overflow, mem_req, mem_we;
  logic [DW-1:0] top_data, mem_wdata;
  logic [SW-1:0] depth;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opstk_unit #(.DATA_W(DW), .WIN(WIN), .MEM_DEPTH(MDEP)) dut (
    .clk(clk), .rst_ni(rst_ni), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .busy(busy), .top_data(top_data), .depth(depth),
    .underflow(underflow), .overflow(overflow), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory responder with random acknowledge delay
  logic [DW-1:0] mem [MDEP];
  int lat = 0, wr_cnt = 0, rd_cnt = 0, hold_err = 0;
  int last_wr_addr = 0, last_rd_addr = 0;
  logic [DW-1:0] last_wr_data = '0;
  bit prev_wait = 0;

  always @(posedge clk) begin
    prev_wait <= mem_req && !mem_ack;
    if (prev_wait && !mem_req) hold_err <= hold_err + 1;
    if (mem_req && !mem_ack) begin
      if (lat == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          wr_cnt        <= wr_cnt + 1;
          last_wr_addr  <= int'(mem_addr);
          last_wr_data  <= mem_wdata;
        end else begin
          mem_rdata    <= mem[mem_addr];
          rd_cnt       <= rd_cnt + 1;
          last_rd_addr <= int'(mem_addr);
        end
      end else lat <= lat - 1;
    end else begin
      mem_ack <= 1'b0;
      lat     <= int'($urandom_range(0, 2));
    end
  end

  // bench model
  logic [DW-1:0] mdl [CAP];
  int  mdepth = 0, mreg = 0;
  bit  munf = 0, movf = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [DW-1:0] calc(input logic [2:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      3'd2:    return a + b;
      3'd3:    return a - b;
      3'd4:    return a & b;
      default: return a | b;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1 push";
      3'd1: return "R4 pop";
      3'd3: return "R3 sub";
      3'd2, 3'd4, 3'd5: return "R2 op";
      default: return "R10 unused code";
    endcase
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    mdepth = 0; mreg = 0; munf = 0; movf = 0;
  endtask

  task automatic do_op(input logic [2:0] op, input logic [DW-1:0] d);
    int  mm_b, wr0, rd0;
    bit  stall, bsy;
    logic [DW-1:0] res;
    string t;
    mm_b = mdepth - mreg; wr0 = wr_cnt; rd0 = rd_cnt; stall = 0; bsy = 0;
    t = tag_of(op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    #1;
    while (!cmd_ready) begin stall = 1; @(negedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    while (busy) begin bsy = 1; @(negedge clk); end
    if (op == 3'd0) begin
      if (mdepth == CAP) begin
        movf = 1;
        check("R9 overflow no spill", wr_cnt - wr0, 0);
      end else begin
        if (mreg == WIN) begin
          check("R5 spill count", wr_cnt - wr0, 1);
          check("R5 spill addr", last_wr_addr, mm_b);
          check("R5 spill data", last_wr_data, mdl[mdepth-WIN]);
          check("R5 push stalled", stall, 1);
        end else mreg++;
        mdl[mdepth] = d;
        mdepth++;
      end
    end else if (op <= 3'd5) begin
      if (mdepth < 2) munf = 1;
      else begin
        res = calc(op, mdl[mdepth-2], mdl[mdepth-1]);
        mdepth--;
        if (op != 3'd1) mdl[mdepth-1] = res;
        mreg--;
        if (mreg == 1 && mm_b > 0) begin
          check("R6 refill count", rd_cnt - rd0, 1);
          check("R6 refill addr", last_rd_addr, mm_b - 1);
          check("R6 busy seen", bsy, 1);
          mreg = 2;
        end
      end
    end
    check({t, " depth"}, 32'(depth), mdepth);
    if (mdepth > 0) check({t, " top"}, 32'(top_data), 32'(mdl[mdepth-1]));
    check("R8 underflow flag", 32'(underflow), 32'(munf));
    check("R9 overflow flag", 32'(overflow), 32'(movf));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R11 reset state
    check("R11 depth", 32'(depth), 0);
    check("R11 busy", 32'(busy), 0);
    check("R11 mem_req", 32'(mem_req), 0);
    check("R11 underflow", 32'(underflow), 0);
    check("R11 overflow", 32'(overflow), 0);
    check("R11 cmd_ready", 32'(cmd_ready), 1);

    // R3 postfix subtract order, R2 and/or/add, R4 pop
    do_op(3'd0, 16'd7);
    do_op(3'd0, 16'd5);
    do_op(3'd3, 16'd0);
    do_op(3'd0, 16'h00f0);
    do_op(3'd4, 16'd0);
    do_op(3'd0, 16'd3);
    do_op(3'd5, 16'd0);
    do_op(3'd0, 16'hfffe);
    do_op(3'd2, 16'd0);
    do_op(3'd0, 16'h1234);
    do_op(3'd1, 16'd0);
    // R10 unused codes
    do_op(3'd6, 16'hdead);
    do_op(3'd7, 16'hbeef);
    // R8 pop on single entry
    do_op(3'd1, 16'd0);

    // R5 fill through spills, R9 overflow at capacity
    do_reset();
    for (int i = 0; i < CAP; i++) do_op(3'd0, 16'(16'h100 + i * 3));
    do_op(3'd0, 16'h5555);
    // R6 operate down through refills
    for (int i = 0; i < CAP - 1; i++) do_op(3'(2 + i % 4), 16'd0);
    do_op(3'd2, 16'd0);

    // constrained random walk
    do_reset();
    for (int i = 0; i < 500; i++) begin
      int r;
      logic [2:0] op;
      r = int'($urandom_range(0, 99));
      if (r < 45)      op = 3'd0;
      else if (r < 58) op = 3'd1;
      else if (r < 68) op = 3'd2;
      else if (r < 78) op = 3'd3;
      else if (r < 86) op = 3'd4;
      else if (r < 95) op = 3'd5;
      else             op = 3'(6 + r % 2);
      do_op(op, 16'($urandom));
    end

    check("R7 request held until ack", hold_err, 0);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule